// File: doc/BRIEF.md
# Effective Address Decoder for Register/Memory Operand Bytes

This block takes the operand-specifier byte that follows an opcode and turns it into an effective address. Where the addressing form calls for them, it also takes an optional scale-index-base byte and a displacement of 1, 2 or 4 bytes. Bytes arrive one per accepted handshake on a valid/ready fetch port. The block reads two general registers through a combinational register-file read port. Register numbering is 0..7 = AX, CX, DX, BX, SP, BP, SI, DI.

A decode begins with a `start` pulse while the block is idle. The block samples `addr32` (1 = 32-bit addressing, 0 = 16-bit) and `seg_override` (1 = a segment prefix is already active) on that pulse. It then consumes exactly the bytes the form needs. It reports the register field, a memory/register flag, the second register number, the effective address, whether the stack segment should be the default, and how many bytes were consumed. `done` is a one-cycle pulse, and the result outputs hold their values until the next `done`.

Top module: `agen_modrm`

## Requirements
- R1: The first byte splits into mode = bits 7:6, register field = bits 5:3 and r/m = bits 2:0. Mode 3 gives is_mem = 0, rm_reg = r/m, eff_addr = 0, stack_seg = 0 and byte_count = 1, and no further byte is consumed.
- R2: In 16-bit mode, r/m 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP, BX, each using only the low 16 bits of the registers.
- R3: In 16-bit mode, mode 1 adds a sign-extended 8-bit displacement and mode 2 a sign-extended 16-bit one. Mode 0 with r/m 6 uses a 16-bit displacement alone. The result is reduced modulo 2^16.
- R4: In 16-bit mode, r/m 2, r/m 3, and r/m 6 with nonzero mode select the stack segment by default.
- R5: In 32-bit mode with r/m other than 4, the base is register r/m. Mode 0 with r/m 5 instead uses a 32-bit displacement alone. Mode 1 adds a sign-extended 8-bit displacement and mode 2 adds a 32-bit displacement.
- R6: In 32-bit mode with r/m 4 and mode below 3, a second byte is consumed. Its bits 7:6 give the shift amount, bits 5:3 the index register and bits 2:0 the base register. The address is base + (index << shift), and index number 4 contributes zero.
- R7: In a scale-index-base form with base number 5 and mode 0, no base register is used; a 32-bit displacement is consumed and added instead.
- R8: In 32-bit mode, a scale-index-base base of 4, or r/m 5 with nonzero mode, selects the stack segment by default.
- R9: When seg_override was 1 at start, stack_seg is 0 for every form.
- R10: Displacement bytes are taken least significant first. byte_count equals 1, plus 1 if a scale-index-base byte was used, plus the displacement length, for a range of 1 to 6.
- R11: A byte is consumed only in a cycle with fetch_valid and fetch_ready both high, so stalls are tolerated. addr32 and seg_override changes after start have no effect. done is a single-cycle pulse, and fetch_ready is low in reset and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a decode (accepted while idle) |
| addr32 | input | 1 | 1 = 32-bit addressing, 0 = 16-bit; sampled on start |
| seg_override | input | 1 | Segment prefix already active; sampled on start |
| fetch_valid | input | 1 | Instruction byte available |
| fetch_byte | input | 8 | Instruction byte |
| fetch_ready | output | 1 | Block accepts a byte this cycle |
| rd_idx_a | output | 3 | Register number for the base read |
| rd_data_a | input | ADDR_W | Base register value |
| rd_idx_b | output | 3 | Register number for the index read |
| rd_data_b | input | ADDR_W | Index register value |
| done | output | 1 | One-cycle result strobe |
| reg_field | output | 3 | Register field of the first byte |
| is_mem | output | 1 | 1 = memory operand, 0 = register operand |
| rm_reg | output | 3 | Second register number (r/m field) |
| eff_addr | output | ADDR_W | Effective address |
| stack_seg | output | 1 | Stack segment is the default |
| byte_count | output | 3 | Bytes consumed for this operand |

## Verification
A wrong state transition in the fetch sequencer shows up as a byte count mismatch. It also shows as a stall that never reaches `done`, or as `done` arriving before every byte offered has been taken. The bench counts handshakes, so the error is visible at the end of that same decode. A wrong displacement length or byte order appears at once in `eff_addr`. The random stimulus includes negative 8-bit and 16-bit displacements and 16-bit sums that wrap. A latched mode or override bit that is lost after start corrupts `eff_addr` or `stack_seg` on the very next strobe, because the bench toggles those inputs in the middle of a decode.

// File: rtl/agen_pkg.sv
package agen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_MODRM = 3'd1,
        ST_SIB   = 3'd2,
        ST_DISP  = 3'd3,
        ST_CALC  = 3'd4
    } agen_state_e;

    typedef struct packed {
        logic [1:0] md;
        logic [2:0] reg_f;
        logic [2:0] rm;
    } modrm_t;

    typedef struct packed {
        logic [1:0] scale;
        logic [2:0] idx;
        logic [2:0] base;
    } sib_t;

    // Widest displacement the 32-bit forms carry
    localparam int DISP_BYTES = 4;
    localparam int DISP_W     = DISP_BYTES * 8;

    localparam logic [2:0] GPR_BX = 3'd3;
    localparam logic [2:0] GPR_SP = 3'd4;
    localparam logic [2:0] GPR_BP = 3'd5;
    localparam logic [2:0] GPR_SI = 3'd6;
    localparam logic [2:0] GPR_DI = 3'd7;

    localparam logic [1:0] MD_NODISP = 2'd0;
    localparam logic [1:0] MD_DISP8  = 2'd1;
    localparam logic [1:0] MD_DISPW  = 2'd2;
    localparam logic [1:0] MD_REG    = 2'd3;

    function automatic logic wants_sib(input logic a32, input modrm_t m);
        return a32 && (m.md != MD_REG) && (m.rm == GPR_SP);
    endfunction

    // Displacement length in bytes for a memory form
    function automatic logic [2:0] disp_len(input logic a32, input modrm_t m, input sib_t s);
        logic [2:0] n;
        n = 3'd0;
        case (m.md)
            MD_DISP8: n = 3'd1;
            MD_DISPW: n = a32 ? 3'd4 : 3'd2;
            MD_NODISP: begin
                if (a32) begin
                    if ((m.rm == GPR_BP) || ((m.rm == GPR_SP) && (s.base == GPR_BP)))
                        n = 3'd4;
                end else if (m.rm == 3'd6) begin
                    n = 3'd2;
                end
            end
            default: n = 3'd0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/agen_fetch_fsm.sv
module agen_fetch_fsm
    import agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              addr32,
    input  logic              seg_override,
    input  logic              fetch_valid,
    input  logic [7:0]        fetch_byte,
    output logic              fetch_ready,
    output modrm_t            modrm_o,
    output sib_t              sib_o,
    output logic              has_sib_o,
    output logic [DISP_W-1:0] disp_o,
    output logic [2:0]        dlen_o,
    output logic              a32_o,
    output logic              ovr_o,
    output logic              calc_o
);

    agen_state_e       state_q;
    modrm_t            modrm_q;
    sib_t              sib_q;
    logic              has_sib_q;
    logic [DISP_W-1:0] disp_q;
    logic [2:0]        dlen_q;
    logic [2:0]        dcnt_q;
    logic              a32_q;
    logic              ovr_q;

    modrm_t     in_m;
    sib_t       in_s;
    logic [2:0] len_after_modrm;
    logic [2:0] len_after_sib;

    always_comb begin
        in_m            = modrm_t'(fetch_byte);
        in_s            = sib_t'(fetch_byte);
        len_after_modrm = disp_len(a32_q, in_m, sib_t'(8'h00));
        len_after_sib   = disp_len(a32_q, modrm_q, in_s);
    end

    assign fetch_ready = (state_q == ST_MODRM) || (state_q == ST_SIB) || (state_q == ST_DISP);
    assign calc_o      = (state_q == ST_CALC);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            modrm_q   <= '0;
            sib_q     <= '0;
            has_sib_q <= 1'b0;
            disp_q    <= '0;
            dlen_q    <= '0;
            dcnt_q    <= '0;
            a32_q     <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q   <= ST_MODRM;
                        a32_q     <= addr32;
                        ovr_q     <= seg_override;
                        sib_q     <= '0;
                        has_sib_q <= 1'b0;
                        disp_q    <= '0;
                        dlen_q    <= '0;
                        dcnt_q    <= '0;
                    end
                end
                ST_MODRM: begin
                    if (fetch_valid) begin
                        modrm_q <= in_m;
                        if (in_m.md == MD_REG) begin
                            state_q <= ST_CALC;
                        end else if (wants_sib(a32_q, in_m)) begin
                            state_q <= ST_SIB;
                        end else begin
                            dlen_q  <= len_after_modrm;
                            state_q <= (len_after_modrm == 3'd0) ? ST_CALC : ST_DISP;
                        end
                    end
                end
                ST_SIB: begin
                    if (fetch_valid) begin
                        sib_q     <= in_s;
                        has_sib_q <= 1'b1;
                        dlen_q    <= len_after_sib;
                        state_q   <= (len_after_sib == 3'd0) ? ST_CALC : ST_DISP;
                    end
                end
                ST_DISP: begin
                    if (fetch_valid) begin
                        for (int k = 0; k < DISP_BYTES; k++) begin
                            if (dcnt_q == 3'(k))
                                disp_q[k*8 +: 8] <= fetch_byte;
                        end
                        dcnt_q <= dcnt_q + 3'd1;
                        if ((dcnt_q + 3'd1) == dlen_q)
                            state_q <= ST_CALC;
                    end
                end
                ST_CALC: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign modrm_o   = modrm_q;
    assign sib_o     = sib_q;
    assign has_sib_o = has_sib_q;
    assign disp_o    = disp_q;
    assign dlen_o    = dlen_q;
    assign a32_o     = a32_q;
    assign ovr_o     = ovr_q;

    // An accepted start opens the fetch window on the next cycle
    assert_start_opens_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start) |=> fetch_ready);

    // The scale-index-base byte is only fetched in 32-bit addressing
    assert_sib_only_wide_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SIB) |-> a32_q);

    // Displacement collection never runs past its length
    assert_disp_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DISP) |-> (dcnt_q < dlen_q));

endmodule

// File: rtl/agen_ea_calc.sv
module agen_ea_calc
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              a32,
    input  logic              ovr,
    input  modrm_t            modrm,
    input  sib_t              sib,
    input  logic [DISP_W-1:0] disp,
    input  logic [2:0]        dlen,
    output logic [2:0]        idx_a,
    input  logic [ADDR_W-1:0] val_a,
    output logic [2:0]        idx_b,
    input  logic [ADDR_W-1:0] val_b,
    output logic [ADDR_W-1:0] ea,
    output logic              stack_dflt
);

    localparam logic [ADDR_W-1:0] LOW16 = {{(ADDR_W-16){1'b0}}, 16'hFFFF};

    logic              use_a;
    logic              use_b;
    logic [1:0]        shamt;
    logic              stk;
    logic [ADDR_W-1:0] dext;
    logic [ADDR_W-1:0] a_term;
    logic [ADDR_W-1:0] b_term;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        use_a = 1'b0;
        use_b = 1'b0;
        idx_a = GPR_BX;
        idx_b = GPR_SI;
        shamt = 2'd0;
        stk   = 1'b0;
        if (a32) begin
            if (modrm.rm == GPR_SP) begin
                idx_a = sib.base;
                use_a = !((sib.base == GPR_BP) && (modrm.md == MD_NODISP));
                idx_b = sib.idx;
                use_b = (sib.idx != GPR_SP);
                shamt = sib.scale;
                stk   = (sib.base == GPR_SP);
            end else begin
                idx_a = modrm.rm;
                use_a = !((modrm.rm == GPR_BP) && (modrm.md == MD_NODISP));
                stk   = (modrm.rm == GPR_BP) && (modrm.md != MD_NODISP);
            end
        end else begin
            case (modrm.rm)
                3'd0: begin idx_a = GPR_BX; idx_b = GPR_SI; use_a = 1'b1; use_b = 1'b1; end
                3'd1: begin idx_a = GPR_BX; idx_b = GPR_DI; use_a = 1'b1; use_b = 1'b1; end
                3'd2: begin idx_a = GPR_BP; idx_b = GPR_SI; use_a = 1'b1; use_b = 1'b1; stk = 1'b1; end
                3'd3: begin idx_a = GPR_BP; idx_b = GPR_DI; use_a = 1'b1; use_b = 1'b1; stk = 1'b1; end
                3'd4: begin idx_b = GPR_SI; use_b = 1'b1; end
                3'd5: begin idx_b = GPR_DI; use_b = 1'b1; end
                3'd6: begin
                    idx_a = GPR_BP;
                    use_a = (modrm.md != MD_NODISP);
                    stk   = (modrm.md != MD_NODISP);
                end
                default: begin idx_a = GPR_BX; use_a = 1'b1; end
            endcase
        end

        case (dlen)
            3'd1:    dext = ADDR_W'(signed'(disp[7:0]));
            3'd2:    dext = ADDR_W'(signed'(disp[15:0]));
            3'd4:    dext = ADDR_W'(signed'(disp[31:0]));
            default: dext = '0;
        endcase

        a_term = use_a ? (a32 ? val_a : (val_a & LOW16)) : '0;
        b_term = use_b ? ((a32 ? val_b : (val_b & LOW16)) << shamt) : '0;
        sum    = a_term + b_term + dext;

        if (modrm.md == MD_REG) begin
            ea         = '0;
            stack_dflt = 1'b0;
        end else begin
            ea         = a32 ? sum : (sum & LOW16);
            stack_dflt = stk && !ovr;
        end
    end

endmodule

// File: rtl/agen_modrm.sv
module agen_modrm
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              addr32,
    input  logic              seg_override,
    input  logic              fetch_valid,
    input  logic [7:0]        fetch_byte,
    output logic              fetch_ready,
    output logic [2:0]        rd_idx_a,
    input  logic [ADDR_W-1:0] rd_data_a,
    output logic [2:0]        rd_idx_b,
    input  logic [ADDR_W-1:0] rd_data_b,
    output logic              done,
    output logic [2:0]        reg_field,
    output logic              is_mem,
    output logic [2:0]        rm_reg,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              stack_seg,
    output logic [2:0]        byte_count
);

    modrm_t            modrm;
    sib_t              sib;
    logic              has_sib;
    logic [DISP_W-1:0] disp;
    logic [2:0]        dlen;
    logic              a32;
    logic              ovr;
    logic              calc;
    logic [ADDR_W-1:0] ea_comb;
    logic              stk_comb;

    agen_fetch_fsm u_fetch (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .addr32       (addr32),
        .seg_override (seg_override),
        .fetch_valid  (fetch_valid),
        .fetch_byte   (fetch_byte),
        .fetch_ready  (fetch_ready),
        .modrm_o      (modrm),
        .sib_o        (sib),
        .has_sib_o    (has_sib),
        .disp_o       (disp),
        .dlen_o       (dlen),
        .a32_o        (a32),
        .ovr_o        (ovr),
        .calc_o       (calc)
    );

    agen_ea_calc #(.ADDR_W(ADDR_W)) u_calc (
        .a32        (a32),
        .ovr        (ovr),
        .modrm      (modrm),
        .sib        (sib),
        .disp       (disp),
        .dlen       (dlen),
        .idx_a      (rd_idx_a),
        .val_a      (rd_data_a),
        .idx_b      (rd_idx_b),
        .val_b      (rd_data_b),
        .ea         (ea_comb),
        .stack_dflt (stk_comb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            reg_field  <= '0;
            is_mem     <= 1'b0;
            rm_reg     <= '0;
            eff_addr   <= '0;
            stack_seg  <= 1'b0;
            byte_count <= '0;
        end else begin
            done <= calc;
            if (calc) begin
                reg_field  <= modrm.reg_f;
                is_mem     <= (modrm.md != MD_REG);
                rm_reg     <= modrm.rm;
                eff_addr   <= ea_comb;
                stack_seg  <= stk_comb;
                byte_count <= 3'd1 + {2'b00, has_sib} + dlen;
            end
        end
    end

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_reg_form_R1: assert property (@(posedge clk) disable iff (rst)
        (done && !is_mem) |-> (byte_count == 3'd1 && !stack_seg && eff_addr == '0));

    assert_wrap16_R3: assert property (@(posedge clk) disable iff (rst)
        (done && !a32) |-> (eff_addr[ADDR_W-1:16] == '0));

    assert_override_R9: assert property (@(posedge clk) disable iff (rst)
        (done && ovr) |-> !stack_seg);

    assert_count_range_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (byte_count >= 3'd1 && byte_count <= 3'd6));

endmodule

// File: tb/agen_modrm_bench.sv
`timescale 1ns/1ps
module agen_modrm_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          addr32 = 1'b0;
    logic          seg_override = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [7:0]    fetch_byte = 8'h00;
    logic          fetch_ready;
    logic [2:0]    rd_idx_a;
    logic [AW-1:0] rd_data_a;
    logic [2:0]    rd_idx_b;
    logic [AW-1:0] rd_data_b;
    logic          done;
    logic [2:0]    reg_field;
    logic          is_mem;
    logic [2:0]    rm_reg;
    logic [AW-1:0] eff_addr;
    logic          stack_seg;
    logic [2:0]    byte_count;

    logic [31:0] rf [8];

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    assign rd_data_a = rf[rd_idx_a];
    assign rd_data_b = rf[rd_idx_b];

    agen_modrm #(.ADDR_W(AW)) u_agen_modrm (
        .clk (clk), .rst (rst), .start (start), .addr32 (addr32),
        .seg_override (seg_override), .fetch_valid (fetch_valid),
        .fetch_byte (fetch_byte), .fetch_ready (fetch_ready),
        .rd_idx_a (rd_idx_a), .rd_data_a (rd_data_a),
        .rd_idx_b (rd_idx_b), .rd_data_b (rd_data_b),
        .done (done), .reg_field (reg_field), .is_mem (is_mem),
        .rm_reg (rm_reg), .eff_addr (eff_addr), .stack_seg (stack_seg),
        .byte_count (byte_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input bit a32, input bit ovr, input logic [7:0] m,
                                  input logic [7:0] s, input logic [31:0] d,
                                  output logic [31:0] ea, output bit stk,
                                  output int nb, output int dl, output bit sibp);
        logic [1:0]  md;
        logic [2:0]  rm;
        logic [31:0] b;
        logic [31:0] x;
        logic [31:0] dx;
        md = m[7:6]; rm = m[2:0];
        b = 0; x = 0; dx = 0; ea = 0; stk = 0; dl = 0; sibp = 0;
        if (md == 2'd3) begin
            nb = 1;
            return;
        end
        if (a32) begin
            if (rm == 3'd4) begin
                sibp = 1;
                x = (s[5:3] == 3'd4) ? 32'h0 : (rf[s[5:3]] << s[7:6]);
                if (s[2:0] == 3'd5 && md == 2'd0) dl = 4;
                else b = rf[s[2:0]];
                stk = (s[2:0] == 3'd4);
            end else if (rm == 3'd5 && md == 2'd0) begin
                dl = 4;
            end else begin
                b = rf[rm];
                stk = (rm == 3'd5);
            end
            if (md == 2'd1) dl = 1;
            if (md == 2'd2) dl = 4;
        end else begin
            case (rm)
                3'd0: b = {16'h0, rf[3][15:0]} + {16'h0, rf[6][15:0]};
                3'd1: b = {16'h0, rf[3][15:0]} + {16'h0, rf[7][15:0]};
                3'd2: b = {16'h0, rf[5][15:0]} + {16'h0, rf[6][15:0]};
                3'd3: b = {16'h0, rf[5][15:0]} + {16'h0, rf[7][15:0]};
                3'd4: b = {16'h0, rf[6][15:0]};
                3'd5: b = {16'h0, rf[7][15:0]};
                3'd6: b = (md == 2'd0) ? 32'h0 : {16'h0, rf[5][15:0]};
                default: b = {16'h0, rf[3][15:0]};
            endcase
            stk = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && md != 2'd0);
            if (md == 2'd1) dl = 1;
            else if (md == 2'd2 || (md == 2'd0 && rm == 3'd6)) dl = 2;
        end
        case (dl)
            1: dx = {{24{d[7]}}, d[7:0]};
            2: dx = {{16{d[15]}}, d[15:0]};
            4: dx = d;
            default: dx = 0;
        endcase
        ea = b + x + dx;
        if (!a32) ea = ea & 32'h0000FFFF;
        if (ovr) stk = 0;
        nb = 1 + int'(sibp) + dl;
    endfunction

    task automatic run_case(input bit a32, input bit ovr, input logic [7:0] m,
                            input logic [7:0] s, input logic [31:0] d, input bit gaps);
        logic [31:0] eea;
        bit          estk;
        int          enb;
        int          edl;
        bit          esib;
        logic [7:0]  strm [6];
        int          n;
        int          sent;
        int          wait_c;
        bit          seen;
        string       t_ea;
        string       t_stk;
        model(a32, ovr, m, s, d, eea, estk, enb, edl, esib);
        strm[0] = m; n = 1;
        if (esib) begin strm[n] = s; n++; end
        for (int k = 0; k < edl; k++) begin strm[n] = d[8*k +: 8]; n++; end

        @(negedge clk);
        addr32 = a32; seg_override = ovr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R11: mode and override are sampled at start only
        addr32 = 1'($urandom); seg_override = 1'($urandom);
        sent = 0; wait_c = 0; seen = 0;
        while (!seen && wait_c < 40) begin
            if (done) begin
                seen = 1;
            end else begin
                fetch_valid = (sent < n) && (!gaps || $urandom_range(0, 2) != 0);
                fetch_byte  = fetch_valid ? strm[sent] : 8'($urandom);
                #1;
                if (fetch_valid && fetch_ready) sent++;
                @(negedge clk);
                fetch_valid = 1'b0;
                wait_c++;
            end
        end

        if (m[7:6] == 2'd3) t_ea = "R1";
        else if (!a32) t_ea = (edl != 0) ? "R3" : "R2";
        else if (esib) t_ea = (s[2:0] == 3'd5 && m[7:6] == 2'd0) ? "R7" : "R6";
        else t_ea = "R5";
        t_stk = ovr ? "R9" : (a32 ? "R8" : "R4");

        chk("R11 done strobe seen", 32'(seen), 32'd1);
        if (seen) begin
            chk({t_ea, " eff_addr"}, eff_addr, eea);
            chk({t_stk, " stack_seg"}, 32'(stack_seg), 32'(estk));
            chk("R10 byte_count", 32'(byte_count), 32'(enb));
            chk("R11 bytes handshaken", 32'(sent), 32'(enb));
            chk("R1 is_mem", 32'(is_mem), 32'(m[7:6] != 2'd3));
            chk("R1 reg_field", 32'(reg_field), 32'(m[5:3]));
            if (m[7:6] == 2'd3) chk("R1 rm_reg", 32'(rm_reg), 32'(m[2:0]));
            #1;
            @(negedge clk);
            chk("R11 done single cycle", 32'(done), 32'd0);
        end
    endtask

    task automatic fill_rf();
        for (int k = 0; k < 8; k++) rf[k] = $urandom;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd7715);
        fill_rf();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset done low", 32'(done), 32'd0);
        chk("R11 reset fetch_ready low", 32'(fetch_ready), 32'd0);
        chk("R1 reset is_mem low", 32'(is_mem), 32'd0);

        // R1 register forms in both modes
        run_case(1'b0, 1'b0, 8'b11_010_101, 8'h00, 32'h0, 1'b0);
        run_case(1'b1, 1'b0, 8'b11_111_000, 8'h00, 32'h0, 1'b1);
        // R2 every 16-bit row, mode 0
        for (int r = 0; r < 8; r++) run_case(1'b0, 1'b0, {2'b00, 3'd1, 3'(r)}, 8'h00, 32'h0000BEEF, 1'b0);
        // R3 16-bit wrap and negative displacements
        rf[3] = 32'hABCD_FFF0; rf[6] = 32'h1234_0020;
        run_case(1'b0, 1'b0, 8'b10_000_000, 8'h00, 32'h0000_7FFF, 1'b0);
        run_case(1'b0, 1'b0, 8'b01_000_000, 8'h00, 32'h0000_0080, 1'b0);
        run_case(1'b0, 1'b0, 8'b00_000_110, 8'h00, 32'h0000_FFFE, 1'b1);
        // R4 stack rows with nonzero mode
        run_case(1'b0, 1'b0, 8'b01_000_110, 8'h00, 32'h0000_00F0, 1'b0);
        run_case(1'b0, 1'b0, 8'b00_000_011, 8'h00, 32'h0, 1'b0);
        // R5 32-bit forms
        run_case(1'b1, 1'b0, 8'b00_000_101, 8'h00, 32'h8765_4321, 1'b0);
        run_case(1'b1, 1'b0, 8'b10_000_001, 8'h00, 32'hFFFF_FF00, 1'b1);
        run_case(1'b1, 1'b0, 8'b01_000_101, 8'h00, 32'h0000_0081, 1'b0);
        // R6 index 4 contributes zero, and full scale
        run_case(1'b1, 1'b0, 8'b00_000_100, 8'b10_100_000, 32'h0, 1'b0);
        run_case(1'b1, 1'b0, 8'b00_000_100, 8'b11_001_010, 32'h0, 1'b0);
        // R7 base 5, mode 0: displacement replaces base
        run_case(1'b1, 1'b0, 8'b00_000_100, 8'b01_110_101, 32'h0010_0000, 1'b1);
        // R8 stack-pointer base, and R9 override on the same form
        run_case(1'b1, 1'b0, 8'b01_000_100, 8'b00_011_100, 32'h0000_0010, 1'b0);
        run_case(1'b1, 1'b1, 8'b01_000_100, 8'b00_011_100, 32'h0000_0010, 1'b0);
        run_case(1'b0, 1'b1, 8'b00_000_010, 8'h00, 32'h0, 1'b0);

        repeat (400) begin
            fill_rf();
            run_case(1'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
                     8'($urandom), $urandom, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule